// File: doc/BRIEF.md
# Quadrature Position Counter with Byte-Serial Access

This block turns a two-phase incremental encoder signal into a 24-bit signed-looking position count. Every legal change of the two phase inputs moves the count by one, up or down depending on the Gray-code order. A jump in which both phases change between two samples is a fault and sets a sticky error output. The phase inputs pass through a synchronizer and are sampled at a rate set by a programmable divider.

Software reaches the block through an 8-bit port pair. A write with `wr_ctrl` high is an opcode; a write with `wr_ctrl` low is a data byte. Data writes fill a 24-bit preset register and data reads drain a 24-bit snapshot register. Both go one byte at a time through a shared pointer that starts at the least significant byte, steps after each access and wraps after the third. Opcodes move values between preset, live count and snapshot, and also clear state. Counting stays off after reset until the block has been told to enable its inputs and to decode in times-four mode. The usual start-up writes opcodes 0x06 and 0x01, then data byte 0x00, then opcodes 0x18, 0x41, 0x38 and 0x02.

Top module: `qdc_counter`

## Requirements
- R1: After reset the live count, snapshot, preset, divider value and byte pointer are zero, `err` is 0, `rdata` is 0 and counting is off.
- R2: With `{enc_a,enc_b}` stepping 00→01→11→10→00 the count rises by one per step, and the reverse order lowers it by one. This happens only once both opcode 0x41 and opcode 0x38 have been written since reset; before that, input changes leave the count alone.
- R3: While counting is on, a change of both phase bits between two samples sets `err` and leaves the count unchanged. `err` stays set until opcode 0x06, which clears it and wins over a fault in the same cycle.
- R4: The count is 24 bits and wraps: one step down from 0 gives 0xFFFFFF, and one step up from 0xFFFFFF gives 0.
- R5: Opcode 0x02 sets the count to 0 and opcode 0x08 copies the preset register into it. Either one wins over an encoder step in the same cycle.
- R6: Opcode 0x10 copies the live count into the snapshot register. The snapshot changes at no other time, so bytes read later belong to one moment even while the count moves.
- R7: A data read (`rd_en`) returns, on `rdata` one clock later, the snapshot byte selected by the pointer: bits 7:0 at pointer 0, then 15:8, then 23:16. The pointer then advances and wraps back to 0 after the third byte.
- R8: Opcode 0x01 returns the byte pointer to 0 (least significant byte).
- R9: A data write stores `wdata` into the preset byte selected by the pointer (pointer 0 = bits 7:0) and advances the pointer the same way a read does.
- R10: Opcode 0x18 loads preset bits 7:0 as the divider value N and restarts the divider. The phase inputs are then sampled once every N+1 clocks, first N+1 clocks after the opcode; with N = 0 they are sampled every clock.
- R11: Opcodes other than 0x01, 0x02, 0x06, 0x08, 0x10, 0x18, 0x38 and 0x41 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one clock per byte |
| wr_ctrl | input | 1 | 1: write is an opcode, 0: write is a data byte |
| wdata | input | 8 | Opcode or data byte |
| rd_en | input | 1 | Read one snapshot byte at the pointer |
| rdata | output | 8 | Byte returned by the last read |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| err | output | 1 | Sticky illegal-transition flag |

## Verification
The bench walks the phase inputs both ways around the Gray cycle and across zero. A wrong direction table or a missing wrap would show as a count off by one or stuck near 0x000001. It reads a snapshot after the count has moved, so a design that reads live bytes returns the new value. It reads four bytes in a row and restarts the pointer part way through, which exposes a pointer that runs past the top byte or ignores its reset. It also steps the inputs before counting is enabled, makes an illegal double jump, sends an unknown opcode, and sets a 256-clock divider. These catch a counter that runs too early, an error flag that is not sticky, and a divider that samples too soon.

// File: rtl/qdc_pkg.sv
package qdc_pkg;
    localparam int unsigned BYTE_W = 8;

    // Control opcodes; the values are fixed by the software that drives the port.
    localparam logic [BYTE_W-1:0] OP_PTR_RESTART = 8'h01;
    localparam logic [BYTE_W-1:0] OP_COUNT_CLEAR = 8'h02;
    localparam logic [BYTE_W-1:0] OP_FAULT_CLEAR = 8'h06;
    localparam logic [BYTE_W-1:0] OP_PRESET_LOAD = 8'h08;
    localparam logic [BYTE_W-1:0] OP_SNAP_TAKE   = 8'h10;
    localparam logic [BYTE_W-1:0] OP_DIV_LOAD    = 8'h18;
    localparam logic [BYTE_W-1:0] OP_MODE_X4     = 8'h38;
    localparam logic [BYTE_W-1:0] OP_INPUTS_ON   = 8'h41;

    // Gray phase to position within one quadrature cycle.
    function automatic logic [1:0] phase_pos(input logic [1:0] ab);
        return {ab[1], ab[1] ^ ab[0]};
    endfunction
endpackage

// File: rtl/qdc_sync.sv
module qdc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign stg_d[i] = d;
        end else begin : g_next
            assign stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        for (int i = 0; i < STAGES; i++) begin
            if (!rst_n) stg_q[i] <= '0;
            else        stg_q[i] <= stg_d[i];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/qdc_divider.sv
module qdc_divider #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PSC_W-1:0] load_val,
    input  logic [PSC_W-1:0] period,
    output logic             tick
);
    logic [PSC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = (cnt_q == '0);
        if (restart)   cnt_d = load_val;
        else if (tick) cnt_d = period;
        else           cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/qdc_quad.sv
module qdc_quad
    import qdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample,
    input  logic [1:0] ab,
    output logic       step_up,
    output logic       step_dn,
    output logic       jump
);
    logic [1:0] last_d, last_q;
    logic [1:0] delta;

    always_comb begin
        delta   = phase_pos(ab) - phase_pos(last_q);
        step_up = sample && (delta == 2'd1);
        step_dn = sample && (delta == 2'd3);
        jump    = sample && (delta == 2'd2);
        // The last sample follows the inputs even while counting is off,
        // so enabling never produces a false step.
        last_d  = sample ? ab : last_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 2'b00;
        else        last_q <= last_d;
    end
endmodule

// File: rtl/qdc_counter.sv
module qdc_counter
    import qdc_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2,
    parameter int PSC_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rdata,
    input  logic              enc_a,
    input  logic              enc_b,
    output logic              err
);
    localparam int NB    = CNT_W / BYTE_W;
    localparam int PTR_W = (NB > 1) ? $clog2(NB) : 1;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  preset;
        logic [CNT_W-1:0]  snap;
        logic [PSC_W-1:0]  psc;
        logic [PTR_W-1:0]  ptr;
        logic [BYTE_W-1:0] rdata;
        logic              fault;
        logic              inputs_on;
        logic              mode_x4;
    } state_t;

    state_t st_d, st_q;

    logic [1:0]       ab_sync;
    logic             tick, step_up, step_dn, jump;
    logic             op_wr, data_wr, div_restart;
    logic [PTR_W-1:0] ptr_next;

    qdc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({enc_a, enc_b}),
        .q    (ab_sync)
    );

    qdc_divider #(.PSC_W(PSC_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (div_restart),
        .load_val(st_q.preset[PSC_W-1:0]),
        .period  (st_q.psc),
        .tick    (tick)
    );

    qdc_quad u_quad (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (tick),
        .ab     (ab_sync),
        .step_up(step_up),
        .step_dn(step_dn),
        .jump   (jump)
    );

    assign op_wr       = wr_en && wr_ctrl;
    assign data_wr     = wr_en && !wr_ctrl;
    assign div_restart = op_wr && (wdata == OP_DIV_LOAD);
    assign ptr_next    = (st_q.ptr == PTR_W'(NB - 1)) ? '0 : st_q.ptr + 1'b1;

    always_comb begin
        st_d = st_q;

        // R2, R3, R4: decoded steps apply only once both enables are in.
        if (st_q.inputs_on && st_q.mode_x4) begin
            if (step_up)      st_d.count = st_q.count + 1'b1;
            else if (step_dn) st_d.count = st_q.count - 1'b1;
            if (jump)         st_d.fault = 1'b1;
        end

        // Opcodes come after the step so that they take priority (R3, R5).
        if (op_wr) begin
            case (wdata)
                OP_PTR_RESTART: st_d.ptr       = '0;
                OP_COUNT_CLEAR: st_d.count     = '0;
                OP_FAULT_CLEAR: st_d.fault     = 1'b0;
                OP_PRESET_LOAD: st_d.count     = st_q.preset;
                OP_SNAP_TAKE:   st_d.snap      = st_q.count;
                OP_DIV_LOAD:    st_d.psc       = st_q.preset[PSC_W-1:0];
                OP_MODE_X4:     st_d.mode_x4   = 1'b1;
                OP_INPUTS_ON:   st_d.inputs_on = 1'b1;
                default:        ; // R11
            endcase
        end

        // R9: preset filled a byte at a time.
        if (data_wr) begin
            for (int b = 0; b < NB; b++) begin
                if (st_q.ptr == PTR_W'(b)) st_d.preset[b*BYTE_W +: BYTE_W] = wdata;
            end
        end

        // R7: snapshot drained a byte at a time.
        if (rd_en) begin
            for (int b = 0; b < NB; b++) begin
                if (st_q.ptr == PTR_W'(b)) st_d.rdata = st_q.snap[b*BYTE_W +: BYTE_W];
            end
        end

        if ((data_wr || rd_en) && !(op_wr && wdata == OP_PTR_RESTART)) st_d.ptr = ptr_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
    assign err   = st_q.fault;
endmodule

// File: rtl/qdc_counter_chk.sv
module qdc_counter_chk #(
    parameter int CNT_W = 24,
    parameter int PTR_W = 2,
    parameter int NB    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_ctrl,
    input logic [7:0]       wdata,
    input logic             err,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] snap,
    input logic [CNT_W-1:0] preset,
    input logic [PTR_W-1:0] ptr
);
    logic op_clear, op_load, op_snap, op_ptr, op_fclr;
    assign op_clear = wr_en && wr_ctrl && (wdata == 8'h02);
    assign op_load  = wr_en && wr_ctrl && (wdata == 8'h08);
    assign op_snap  = wr_en && wr_ctrl && (wdata == 8'h10);
    assign op_ptr   = wr_en && wr_ctrl && (wdata == 8'h01);
    assign op_fclr  = wr_en && wr_ctrl && (wdata == 8'h06);

    assert_fault_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_fclr |=> !err);

    assert_count_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_clear |=> (count == '0));

    assert_preset_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_load |=> (count == $past(preset)));

    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_clear || op_load) |=>
            (count == $past(count)) || (count == $past(count) + 1'b1) ||
            (count == $past(count) - 1'b1));

    assert_snap_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_snap |=> (snap == $past(count)));

    assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !op_snap |=> $stable(snap));

    assert_ptr_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_ptr |=> (ptr == '0));

    assert_ptr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ptr < PTR_W'(NB));
endmodule

bind qdc_counter qdc_counter_chk #(.CNT_W(CNT_W), .PTR_W(PTR_W), .NB(NB)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_ctrl(wr_ctrl),
    .wdata  (wdata),
    .err    (err),
    .count  (st_q.count),
    .snap   (st_q.snap),
    .preset (st_q.preset),
    .ptr    (st_q.ptr)
);

// File: tb/qdc_counter_bench.sv
module qdc_counter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_ctrl = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       enc_a = 1'b0;
    logic       enc_b = 1'b0;
    logic       err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    qdc_counter u_qdc_counter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctrl(wr_ctrl),
        .wdata(wdata), .rd_en(rd_en), .rdata(rdata),
        .enc_a(enc_a), .enc_b(enc_b), .err(err)
    );

    // {a,b} to drive, expected count afterwards
    localparam logic [25:0] VEC [12] = '{
        {2'b01, 24'h000001}, {2'b11, 24'h000002}, {2'b10, 24'h000003},
        {2'b00, 24'h000004}, {2'b10, 24'h000003}, {2'b11, 24'h000002},
        {2'b01, 24'h000001}, {2'b00, 24'h000000}, {2'b10, 24'hFFFFFF},
        {2'b11, 24'hFFFFFE}, {2'b10, 24'hFFFFFF}, {2'b00, 24'h000000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(input logic [7:0] code);
        @(negedge clk); wr_en = 1'b1; wr_ctrl = 1'b1; wdata = code;
        @(negedge clk); wr_en = 1'b0; wr_ctrl = 1'b0;
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wr_ctrl = 1'b0; wdata = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic get(output logic [7:0] b);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; b = rdata;
    endtask

    task automatic read_count(output logic [23:0] v);
        logic [7:0] b0, b1, b2;
        op(8'h01); op(8'h10);
        get(b0); get(b1); get(b2);
        v = {b2, b1, b0};
    endtask

    task automatic drive_ab(input logic [1:0] ab);
        @(negedge clk); {enc_a, enc_b} = ab;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] v;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", rdata, 0);
        chk("R1 err", err, 0);
        read_count(v);
        chk("R1 count", v, 0);

        // R2 no counting before both enables
        drive_ab(2'b01); drive_ab(2'b11);
        read_count(v);
        chk("R2 disabled", v, 0);
        drive_ab(2'b00);
        op(8'h41);
        drive_ab(2'b01);
        read_count(v);
        chk("R2 only inputs on", v, 0);
        drive_ab(2'b00);

        // start-up order
        op(8'h06); op(8'h01); put(8'h00); op(8'h18);
        op(8'h41); op(8'h38); op(8'h02);

        // R2 R4 table walk
        for (int i = 0; i < 12; i++) begin
            drive_ab(VEC[i][25:24]);
            read_count(v);
            chk("R2/R4 table", v, VEC[i][23:0]);
        end
        chk("R3 no fault on legal steps", err, 0);

        // R3 illegal double change
        drive_ab(2'b11);
        read_count(v);
        chk("R3 count held", v, 0);
        chk("R3 fault set", err, 1);
        op(8'h06);
        chk("R3 fault cleared", err, 0);

        // R11 unknown opcode
        drive_ab(2'b00);
        chk("R3 fault again", err, 1);
        op(8'h55); op(8'h00);
        chk("R11 fault kept", err, 1);
        read_count(v);
        chk("R11 count kept", v, 0);
        op(8'h06);

        // R9 R5 preset load
        op(8'h01); put(8'h56); put(8'h34); put(8'h12); op(8'h08);
        read_count(v);
        chk("R5 R9 preset copy", v, 24'h123456);

        // R6 snapshot coherence
        op(8'h01); op(8'h10);
        drive_ab(2'b01);
        get(b); v[7:0] = b; get(b); v[15:8] = b; get(b); v[23:16] = b;
        chk("R6 snapshot old", v, 24'h123456);
        read_count(v);
        chk("R6 snapshot new", v, 24'h123457);

        // R7 pointer wrap, R8 restart
        op(8'h01);
        get(b); chk("R7 byte0", b, 8'h57);
        get(b); chk("R7 byte1", b, 8'h34);
        get(b); chk("R7 byte2", b, 8'h12);
        get(b); chk("R7 wrap", b, 8'h57);
        op(8'h01);
        get(b); get(b); op(8'h01);
        get(b); chk("R8 restart", b, 8'h57);

        // R4 wrap upward
        op(8'h01); put(8'hFF); put(8'hFF); put(8'hFF); op(8'h08);
        drive_ab(2'b11);
        read_count(v);
        chk("R4 up wrap", v, 0);

        // R5 clear
        drive_ab(2'b10);
        op(8'h02);
        read_count(v);
        chk("R5 clear", v, 0);

        // R10 divider of 256 clocks
        op(8'h01); put(8'hFF); op(8'h18);
        drive_ab(2'b00);
        read_count(v);
        chk("R10 not yet sampled", v, 0);
        repeat (300) @(negedge clk);
        read_count(v);
        chk("R10 sampled", v, 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule